// File: doc/BRIEF.md
# Expansion Bus Cycle Sequencer with Refresh

This block turns single-byte transfer requests from a host into timed cycles on an 8-bit expansion bus. The bus has separate address and data lines. Four transfer kinds are supported: memory read, memory write, I/O read and I/O write. A memory cycle is shorter than an I/O cycle. An adapter that needs more time pulls the bus ready line low, and each clock in which ready is low adds one wait state to the cycle.

A free-running timer forces a refresh cycle at a fixed clock interval. A refresh that comes due during a host cycle waits for that cycle to end. It then runs before any further host request. The sequencer also watches the channel-check line. When that line is seen high, it raises a non-maskable interrupt request and holds it until software clears it.

Host requests use a valid/ready handshake. The host raises `req_valid` with stable fields and keeps them until it sees `req_ready` high at a clock edge; that edge accepts the request. `req_ready` is low while a cycle runs or a refresh is pending, and it does not depend on `req_valid`. Completion comes back as a one-clock `rsp_valid` pulse. There is no back-pressure on the response, so the host must take the pulse in the clock it appears.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: For the whole of an accepted cycle, `bus_addr` carries the request's 20-bit address. `bus_data_oe` is high and `bus_data_o` carries the write byte only during write cycles. `bus_addr` is zero while the bus is idle.
- R1 (continued): One clock after a host cycle's last clock, `rsp_valid` pulses for one clock. For a read, `rsp_rdata` then holds the value that `bus_data_i` had in that last clock. For a write, `rsp_rdata` is zero.
- R2: With ready high, a memory read or memory write keeps its strobe (`mem_rd` or `mem_wr`) high for exactly MEM_CLOCKS clocks (default 4).
- R3: With ready high, an I/O read or I/O write keeps its strobe (`io_rd` or `io_wr`) high for exactly IO_CLOCKS clocks (default 5).
- R4: A refresh becomes due every REFRESH_PERIOD clocks (default 72), counted from reset.
- R4 (continued): A refresh cycle holds `refresh` and `mem_rd` high for REF_CLOCKS clocks (default 4) and ignores ready.
- R4 (continued): During a refresh, `bus_addr` carries an 8-bit row number in bits 7:0, with the upper bits zero. The row starts at 0 and increases by one with each refresh.
- R5: `bus_ready` is sampled at the clock edge that ends the second-to-last clock of a host cycle. Each sampled low keeps the cycle in that clock for one more clock, so every low sample lengthens the cycle by exactly one clock.
- R6: At most one of `mem_rd`, `mem_wr`, `io_rd`, `io_wr` is high in any clock, and all four are low when no cycle is running. Every cycle is followed by at least one idle clock.
- R7: While a cycle runs or a refresh is pending, `req_ready` is low. A refresh that becomes due during a host cycle starts right after that cycle, ahead of a waiting host request.
- R8: `nmi_req` rises one clock after `chan_check` is sampled high. It stays high, even after `chan_check` falls, until `nmi_clear` is sampled high while `chan_check` is low. Setting wins over clearing.
- R9: After reset all strobes, `refresh`, `bus_data_oe`, `rsp_valid` and `nmi_req` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_is_io | input | 1 | 1 selects I/O space, 0 memory |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read byte (zero for writes) |
| bus_addr | output | 20 | Bus address lines |
| bus_data_o | output | 8 | Bus data driven outward |
| bus_data_oe | output | 1 | Data output enable |
| bus_data_i | input | 8 | Bus data read back |
| mem_rd | output | 1 | Memory read strobe (also high during refresh) |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| refresh | output | 1 | Refresh cycle in progress |
| bus_ready | input | 1 | Adapter ready; low adds wait states |
| chan_check | input | 1 | Channel error report |
| nmi_clear | input | 1 | Software clear of the NMI request |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
Each of the four transfer kinds is first run alone with ready held high, which separates the memory length from the I/O length. A memory read is then held with ready low for five clocks, and a closed form gives its length. A long stream of back-to-back random requests, with a random ready pattern, forces refreshes to collide with host cycles and shows that refresh is ordered ahead of a waiting request. An idle stretch shows the bare refresh spacing and the row increment. Channel-check pulses combined with clear attempts, before and after the line falls, tell a held NMI request apart from one that merely follows the line.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int ROW_W  = 8;

  typedef enum logic [2:0] {
    K_MEM_RD  = 3'd0,
    K_MEM_WR  = 3'd1,
    K_IO_RD   = 3'd2,
    K_IO_WR   = 3'd3,
    K_REFRESH = 3'd4
  } xfer_kind_t;

  function automatic logic kind_is_write(xfer_kind_t k);
    return (k == K_MEM_WR) || (k == K_IO_WR);
  endfunction

  function automatic logic kind_is_read(xfer_kind_t k);
    return (k == K_MEM_RD) || (k == K_IO_RD);
  endfunction
endpackage

// File: rtl/xbus_refresh_timer.sv
module xbus_refresh_timer
  import xbus_pkg::*;
#(
  parameter int PERIOD = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic             pending,
  output logic [ROW_W-1:0] row
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic             due;

  assign due = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else begin
      cnt     <= due ? '0 : cnt + 1'b1;
      pending <= due | (pending & ~take);
      if (take) row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int MEM_CLOCKS = 4,
  parameter int IO_CLOCKS  = 5,
  parameter int REF_CLOCKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_io,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              ref_pending,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              ref_take,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              busy,
  output xfer_kind_t        kind,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int MAX_A   = (MEM_CLOCKS > IO_CLOCKS) ? MEM_CLOCKS : IO_CLOCKS;
  localparam int MAX_LEN = (MAX_A > REF_CLOCKS) ? MAX_A : REF_CLOCKS;
  localparam int PH_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] last_ph;
  logic            at_last;
  logic            stall;
  logic            start_host;
  xfer_kind_t      host_kind;

  always_comb begin
    unique case (kind)
      K_IO_RD, K_IO_WR: last_ph = PH_W'(IO_CLOCKS - 1);
      K_REFRESH:        last_ph = PH_W'(REF_CLOCKS - 1);
      default:          last_ph = PH_W'(MEM_CLOCKS - 1);
    endcase
  end

  always_comb begin
    unique case ({req_is_io, req_write})
      2'b00:   host_kind = K_MEM_RD;
      2'b01:   host_kind = K_MEM_WR;
      2'b10:   host_kind = K_IO_RD;
      default: host_kind = K_IO_WR;
    endcase
  end

  assign at_last    = (phase == last_ph);
  assign stall      = (kind != K_REFRESH) && (phase == last_ph - 1'b1) && !bus_ready;
  assign req_ready  = !busy && !ref_pending;
  assign ref_take   = !busy && ref_pending;
  assign start_host = req_ready && req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      kind      <= K_MEM_RD;
      phase     <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!busy) begin
        if (ref_take) begin
          busy   <= 1'b1;
          kind   <= K_REFRESH;
          phase  <= '0;
          addr_q <= ADDR_W'(ref_row);
        end else if (start_host) begin
          busy    <= 1'b1;
          kind    <= host_kind;
          phase   <= '0;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
      end else if (at_last) begin
        busy <= 1'b0;
        if (kind != K_REFRESH) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= kind_is_read(kind) ? bus_data_i : '0;
        end
      end else if (!stall) begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbus_strobe_decode.sv
module xbus_strobe_decode
  import xbus_pkg::*;
(
  input  logic       busy,
  input  xfer_kind_t kind,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       io_rd,
  output logic       io_wr,
  output logic       refresh,
  output logic       data_oe
);
  always_comb begin
    mem_rd  = busy && ((kind == K_MEM_RD) || (kind == K_REFRESH));
    mem_wr  = busy && (kind == K_MEM_WR);
    io_rd   = busy && (kind == K_IO_RD);
    io_wr   = busy && (kind == K_IO_WR);
    refresh = busy && (kind == K_REFRESH);
    data_oe = busy && kind_is_write(kind);
  end
endmodule

// File: rtl/xbus_nmi_latch.sv
module xbus_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_check,
  input  logic nmi_clear,
  output logic nmi_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_req <= 1'b0;
    else        nmi_req <= chan_check | (nmi_req & ~nmi_clear);
  end
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbus_pkg::*;
#(
  parameter int MEM_CLOCKS     = 4,
  parameter int IO_CLOCKS      = 5,
  parameter int REF_CLOCKS     = 4,
  parameter int REFRESH_PERIOD = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_io,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              refresh,
  input  logic              bus_ready,
  input  logic              chan_check,
  input  logic              nmi_clear,
  output logic              nmi_req
);
  logic              ref_pending;
  logic              ref_take;
  logic [ROW_W-1:0]  ref_row;
  logic              busy;
  xfer_kind_t        kind;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  xbus_refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (ref_take),
    .pending (ref_pending),
    .row     (ref_row)
  );

  xbus_seq #(
    .MEM_CLOCKS (MEM_CLOCKS),
    .IO_CLOCKS  (IO_CLOCKS),
    .REF_CLOCKS (REF_CLOCKS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_is_io   (req_is_io),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .ref_pending (ref_pending),
    .ref_row     (ref_row),
    .ref_take    (ref_take),
    .bus_ready   (bus_ready),
    .bus_data_i  (bus_data_i),
    .busy        (busy),
    .kind        (kind),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  xbus_strobe_decode u_dec (
    .busy    (busy),
    .kind    (kind),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .refresh (refresh),
    .data_oe (bus_data_oe)
  );

  xbus_nmi_latch u_nmi (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_check (chan_check),
    .nmi_clear  (nmi_clear),
    .nmi_req    (nmi_req)
  );

  assign bus_addr   = busy ? addr_q : '0;
  assign bus_data_o = bus_data_oe ? wdata_q : '0;
endmodule

// File: rtl/xbus_checker.sv
module xbus_checker #(
  parameter int MEM_CLOCKS = 4,
  parameter int IO_CLOCKS  = 5,
  parameter int REF_CLOCKS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        io_rd,
  input logic        io_wr,
  input logic        refresh,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        bus_data_oe,
  input logic [19:0] bus_addr,
  input logic        chan_check,
  input logic        nmi_clear,
  input logic        nmi_req
);
  logic        any_strobe;
  logic [15:0] run_cnt;
  logic        prev_io;
  logic        prev_ref;

  assign any_strobe = mem_rd | mem_wr | io_rd | io_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      prev_io  <= 1'b0;
      prev_ref <= 1'b0;
    end else begin
      if (any_strobe) run_cnt <= (run_cnt == 16'hFFFF) ? run_cnt : run_cnt + 1'b1;
      else            run_cnt <= '0;
      prev_io  <= io_rd | io_wr;
      prev_ref <= refresh;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr})); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !any_strobe && !refresh); // R6

  AST_REFRESH_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> !req_ready && mem_rd); // R7

  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (mem_wr || io_wr)); // R1

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && $past(any_strobe)) |-> $stable(bus_addr)); // R1

  AST_RSP_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !any_strobe && $past(any_strobe) && !$past(refresh)); // R1

  AST_MEM_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_strobe && run_cnt != 0 && !prev_io && !prev_ref) |-> run_cnt >= 16'(MEM_CLOCKS)); // R2

  AST_IO_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_strobe && run_cnt != 0 && prev_io) |-> run_cnt >= 16'(IO_CLOCKS)); // R3

  AST_REF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_strobe && run_cnt != 0 && prev_ref) |-> run_cnt == 16'(REF_CLOCKS)); // R4

  AST_NMI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    chan_check |=> nmi_req); // R8

  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_clear) |=> nmi_req); // R8
endmodule

bind xbus_cycle_ctrl xbus_checker #(
  .MEM_CLOCKS (MEM_CLOCKS),
  .IO_CLOCKS  (IO_CLOCKS),
  .REF_CLOCKS (REF_CLOCKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .refresh     (refresh),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .bus_data_oe (bus_data_oe),
  .bus_addr    (bus_addr),
  .chan_check  (chan_check),
  .nmi_clear   (nmi_clear),
  .nmi_req     (nmi_req)
);

// File: tb/tb_xbus_cycle_ctrl.sv
module tb_xbus_cycle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_L = 4;
  localparam int IO_L  = 5;
  localparam int REF_L = 4;
  localparam int REF_P = 72;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_is_io = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [19:0] bus_addr;
  logic [7:0]  bus_data_o;
  logic        bus_data_oe;
  logic [7:0]  bus_data_i = 8'h00;
  logic        mem_rd, mem_wr, io_rd, io_wr, refresh;
  logic        bus_ready = 1'b1, chan_check = 1'b0, nmi_clear = 1'b0;
  logic        nmi_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_cycle_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_io(req_is_io), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_data_i(bus_data_i), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .refresh(refresh), .bus_ready(bus_ready),
    .chan_check(chan_check), .nmi_clear(nmi_clear), .nmi_req(nmi_req)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // kind: 0 mem rd, 1 mem wr, 2 io rd, 3 io wr, 4 refresh
  int   m_busy = 0, m_kind = 0, m_left = 0, m_addr = 0, m_wdata = 0;
  int   m_rsp = 0, m_rdata = 0, m_pend = 0, m_cnt = 0, m_row = 0, m_nmi = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_kind = 0; m_left = 0; m_addr = 0; m_wdata = 0;
      m_rsp = 0; m_rdata = 0; m_pend = 0; m_cnt = 0; m_row = 0; m_nmi = 0;
    end else begin
      int due;
      int took;
      due  = (m_cnt == REF_P - 1);
      took = 0;
      m_rsp = 0;
      if (m_busy == 0) begin
        if (m_pend != 0) begin
          m_busy = 1; m_kind = 4; m_left = REF_L; m_addr = m_row;
          m_row = (m_row + 1) % 256; took = 1;
        end else if (req_valid) begin
          m_busy = 1;
          m_kind = (req_is_io ? 2 : 0) + (req_write ? 1 : 0);
          m_left = req_is_io ? IO_L : MEM_L;
          m_addr = int'(req_addr); m_wdata = int'(req_wdata);
        end
      end else if (m_left == 1) begin
        m_busy = 0;
        if (m_kind != 4) begin
          m_rsp = 1;
          m_rdata = (m_kind == 0 || m_kind == 2) ? int'(bus_data_i) : 0;
        end
      end else if (!(m_left == 2 && m_kind != 4 && !bus_ready)) begin
        m_left--;
      end
      m_pend = (due != 0 || (m_pend != 0 && took == 0)) ? 1 : 0;
      m_cnt  = (due != 0) ? 0 : m_cnt + 1;
      m_nmi  = (chan_check || (m_nmi != 0 && !nmi_clear)) ? 1 : 0;
    end
  end

  // ---------------- per-clock comparison and run monitor ----------------
  int run = 0, run_io = 0, run_ref = 0, run_start = 0;
  int host_len = 0, ref_len = 0;
  int ref_starts[$];
  int ref_behind_req = 0;
  logic prev_any = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic any;
      any = mem_rd | mem_wr | io_rd | io_wr;
      chk("R2", "mem_rd", int'(mem_rd), (m_busy && (m_kind == 0 || m_kind == 4)) ? 1 : 0);
      chk("R2", "mem_wr", int'(mem_wr), (m_busy && m_kind == 1) ? 1 : 0);
      chk("R3", "io_rd",  int'(io_rd),  (m_busy && m_kind == 2) ? 1 : 0);
      chk("R3", "io_wr",  int'(io_wr),  (m_busy && m_kind == 3) ? 1 : 0);
      chk("R4", "refresh", int'(refresh), (m_busy && m_kind == 4) ? 1 : 0);
      chk("R1", "bus_addr", int'(bus_addr), m_busy ? m_addr : 0);
      chk("R1", "bus_data_oe", int'(bus_data_oe), (m_busy && (m_kind == 1 || m_kind == 3)) ? 1 : 0);
      if (bus_data_oe) chk("R1", "bus_data_o", int'(bus_data_o), m_wdata);
      chk("R7", "req_ready", int'(req_ready), (!m_busy && !m_pend) ? 1 : 0);
      chk("R1", "rsp_valid", int'(rsp_valid), m_rsp);
      if (rsp_valid) chk("R1", "rsp_rdata", int'(rsp_rdata), m_rdata);
      chk("R8", "nmi_req", int'(nmi_req), m_nmi);
      chk("R6", "strobe count", $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1 ? 1 : 0, 1);
      if (any) begin
        if (run == 0) begin
          run_start = cyc; run_io = int'(io_rd | io_wr); run_ref = int'(refresh);
          if (refresh && req_valid) ref_behind_req++;
          if (refresh) ref_starts.push_back(cyc);
        end
        if (prev_any && run == 0) chk("R6", "idle gap before cycle", 0, 1);
        run++;
      end else if (run > 0) begin
        if (run_ref != 0) ref_len = run; else host_len = run;
        run = 0;
      end
      prev_any = any;
    end
    bus_data_i <= 8'(cyc * 37 + 11);
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input bit io, input bit wr, input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "req_ready in reset", int'(req_ready), 1);
    chk("R9", "strobes in reset", int'({mem_rd, mem_wr, io_rd, io_wr, refresh}), 0);
    chk("R9", "nmi/rsp/oe in reset", int'({nmi_req, rsp_valid, bus_data_oe}), 0);
    rst_n = 1'b1;

    // R2 / R3: each kind alone with ready high
    issue(1'b0, 1'b0, 20'hA1234, 8'h00); wait_done();
    chk("R2", "memory read length", host_len, MEM_L);
    issue(1'b0, 1'b1, 20'hFFFFF, 8'hC3); wait_done();
    chk("R2", "memory write length", host_len, MEM_L);
    issue(1'b1, 1'b0, 20'h003F8, 8'h00); wait_done();
    chk("R3", "io read length", host_len, IO_L);
    issue(1'b1, 1'b1, 20'h00061, 8'h5A); wait_done();
    chk("R3", "io write length", host_len, IO_L);

    // R5: ready low for five sampled edges from the first strobe clock
    issue(1'b0, 1'b0, 20'h12345, 8'h00);
    while (!mem_rd || refresh) @(negedge clk);
    bus_ready = 1'b0;
    repeat (5) @(negedge clk);
    bus_ready = 1'b1;
    wait_done();
    chk("R5", "stretched memory read length", host_len, MEM_L + 5 - (MEM_L - 2));

    // R7 and mixed patterns: back-to-back random requests with random ready
    fork
      begin
        for (int i = 0; i < 300; i++)
          issue(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                20'($urandom), 8'($urandom));
      end
      begin
        for (int i = 0; i < 2500; i++) begin
          @(negedge clk);
          bus_ready = ($urandom_range(0, 3) != 0);
        end
        bus_ready = 1'b1;
      end
    join
    bus_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7", "refresh taken ahead of a waiting request", ref_behind_req > 0 ? 1 : 0, 1);

    // R4: idle stretch, spacing and row increment
    ref_starts.delete();
    repeat (REF_P * 3 + 10) @(negedge clk);
    chk("R4", "refreshes seen while idle", ref_starts.size() >= 2 ? 1 : 0, 1);
    if (ref_starts.size() >= 2)
      chk("R4", "refresh spacing", ref_starts[1] - ref_starts[0], REF_P);
    chk("R4", "refresh length", ref_len, REF_L);

    // R8: level-held NMI
    @(negedge clk); chan_check = 1'b1;
    @(negedge clk); chan_check = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8", "nmi held after check falls", int'(nmi_req), 1);
    chan_check = 1'b1; nmi_clear = 1'b1;
    @(negedge clk);
    chk("R8", "clear loses to active check", int'(nmi_req), 1);
    chan_check = 1'b0;
    @(negedge clk);
    nmi_clear = 1'b0;
    @(negedge clk);
    chk("R8", "nmi cleared", int'(nmi_req), 0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule